// File: doc/BRIEF.md
# Bit-Slip Serial-to-Parallel Converter

This block turns a serial bit stream, one bit per clock, into 4-bit parallel words. A select input picks the active serial source: the primary line or a second line used for loopback testing. A free-running divide counter marks word boundaries. It provides a short strobe every four clocks and a long strobe every eight clocks. Both are single-cycle enables in the bit-clock domain, not derived clocks.

Word alignment is adjusted by pulses on an asynchronous slip request. Each rising edge of the request is synchronized, and it freezes the divide counter for one clock. The next word is then captured one bit later, so every bit moves down one output position. In wide mode the parallel output updates only on the long strobe. Two instances can then be chained through the serial output, and together they form an 8-bit converter: the downstream instance receives the upstream instance's shifted-out bits. A synchronous reset puts every instance in the same phase.

Top module: `bitslip_deser`

## Requirements
- R1: While reset is applied and after it is released, `par_out` is zero, `ser_out` is zero and both strobes are low. In narrow mode, the first word is loaded on the 4th rising edge after reset is released.
- R2: A captured word puts the earliest of its four bits on `par_out[0]` and the latest on `par_out[3]`.
- R3: With `src_sel` = 0 the serial data comes from `ser_a`, and with `src_sel` = 1 it comes from `ser_b`. The other line has no effect on any output.
- R4: Without slips, `stb_short` is high for one cycle in every 4 and `stb_long` is high for one cycle in every 8. `stb_long` is high only in cycles where `stb_short` is also high, and that happens 4 cycles after the previous `stb_short` pulse.
- R5: With `wide_mode` = 0, `par_out` loads on the rising edge that ends a cycle with `stb_short` high. With `wide_mode` = 1, it loads on the edge that ends a cycle with `stb_long` high. In all other cycles it holds.
- R6: A rising edge of `slip_req` that is first sampled at clock edge s freezes the divide counter at edge s+2. As a result, the next load happens one edge later, and a bit that would have appeared on `par_out[n]` appears on `par_out[n-1]`.
- R7: Keeping `slip_req` high causes only one slip. A further slip requires the line to go low and rise again.
- R8: `ser_out` carries the bit that entered the converter 4 clocks earlier. When two wide-mode instances are chained, with the upstream `ser_out` feeding the downstream `ser_a`, the downstream word holds bits 0 to 3 and the upstream word holds bits 4 to 7 of each 8-bit group.
- R9: In the cycle in which the counter is frozen by a slip, both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_a | input | 1 | Primary serial data |
| ser_b | input | 1 | Loopback serial data |
| src_sel | input | 1 | Source select: 0 = `ser_a`, 1 = `ser_b` |
| wide_mode | input | 1 | 0 = load every 4 bits, 1 = load every 8 bits |
| slip_req | input | 1 | Asynchronous alignment request; each rising edge gives one slip |
| par_out | output | 4 | Parallel word |
| ser_out | output | 1 | Bit shifted out of the register, for cascading |
| stb_short | output | 1 | Divide-by-4 enable strobe |
| stb_long | output | 1 | Divide-by-8 enable strobe |

## Verification
The assertions assume that `slip_req` rises at most once within any three clocks. Slip pulses therefore never merge inside the synchronizer, and the counter is never frozen on two consecutive edges. They also assume that `wide_mode` is stable between reset and the end of a run, because the hold check takes the load condition from the current mode. The stimulus changes the slip line only at falling clock edges, in pulses of two or three clocks separated by much longer gaps, plus one long held level. The mode is set only while reset is applied.

// File: rtl/deser_pkg.sv
package deser_pkg;

   // Divider outputs: single-cycle enables in the bit-clock domain
   typedef struct packed {
      logic short_stb;
      logic long_stb;
   } div_strobes_t;

   // Serial source choice
   typedef enum logic {
      SRC_PRIMARY  = 1'b0,
      SRC_LOOPBACK = 1'b1
   } src_e;

   function automatic bit is_pow2(int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/deser_slip_sync.sv
module deser_slip_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic slip_pulse
);

   if (STAGES < 2) begin : g_bad_stages
      $error("deser_slip_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] meta;
   logic              last_lvl;

   always_ff @(posedge clk) begin
      if (rst) begin
         meta     <= '0;
         last_lvl <= 1'b0;
      end else begin
         meta     <= {meta[STAGES-2:0], async_in};
         last_lvl <= meta[STAGES-1];
      end
   end

   // One cycle per rising edge of the synchronized level
   assign slip_pulse = meta[STAGES-1] & ~last_lvl;

endmodule

// File: rtl/deser_divider.sv
module deser_divider
   import deser_pkg::*;
#(
   parameter int SHORT_DIV = 4,
   parameter int LONG_DIV  = 8
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        hold,
   output logic [$clog2(LONG_DIV)-1:0] count,
   output div_strobes_t                strobes
);

   localparam int CNT_W   = $clog2(LONG_DIV);
   localparam int SHORT_W = $clog2(SHORT_DIV);

   if (!is_pow2(SHORT_DIV) || SHORT_DIV < 2) begin : g_bad_short
      $error("deser_divider: SHORT_DIV must be a power of two, at least 2");
   end
   if (!is_pow2(LONG_DIV) || LONG_DIV <= SHORT_DIV) begin : g_bad_long
      $error("deser_divider: LONG_DIV must be a power of two above SHORT_DIV");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (!hold) begin
         cnt <= (cnt == CNT_W'(LONG_DIV - 1)) ? '0 : cnt + 1'b1;
      end
   end

   // Terminal counts; a swallowed cycle suppresses both enables
   always_comb begin
      strobes.short_stb = (cnt[SHORT_W-1:0] == {SHORT_W{1'b1}}) && !hold;
      strobes.long_stb  = (cnt == CNT_W'(LONG_DIV - 1)) && !hold;
   end

   assign count = cnt;

endmodule

// File: rtl/deser_shifter.sv
module deser_shifter #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         din,
   output logic [W-1:0] next_word,
   output logic         tail_bit
);

   if (W < 2) begin : g_bad_width
      $error("deser_shifter: W must be at least 2");
   end

   logic [W-1:0] sr;

   // New bits enter at the top; the oldest bit sits at index 0
   assign next_word = {din, sr[W-1:1]};

   always_ff @(posedge clk) begin
      if (rst) sr <= '0;
      else     sr <= next_word;
   end

   assign tail_bit = sr[0];

endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser
   import deser_pkg::*;
#(
   parameter int WORD_W      = 4,
   parameter int CASCADE     = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ser_a,
   input  logic              ser_b,
   input  logic              src_sel,
   input  logic              wide_mode,
   input  logic              slip_req,
   output logic [WORD_W-1:0] par_out,
   output logic              ser_out,
   output logic              stb_short,
   output logic              stb_long
);

   localparam int LONG_DIV = WORD_W * CASCADE;
   localparam int CNT_W    = $clog2(LONG_DIV);

   if (!is_pow2(WORD_W) || WORD_W < 2) begin : g_bad_word
      $error("bitslip_deser: WORD_W must be a power of two, at least 2");
   end
   if (!is_pow2(CASCADE) || CASCADE < 2) begin : g_bad_cascade
      $error("bitslip_deser: CASCADE must be a power of two, at least 2");
   end

   // Source selection
   src_e src;
   logic din;
   assign src = src_e'(src_sel);

   always_comb begin
      case (src)
         SRC_PRIMARY: din = ser_a;
         default:     din = ser_b;
      endcase
   end

   // Alignment request path
   logic slip_pulse;

   deser_slip_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst        (rst),
      .async_in   (slip_req),
      .slip_pulse (slip_pulse)
   );

   // Word-boundary counter
   logic [CNT_W-1:0] div_count;
   div_strobes_t     strobes;

   deser_divider #(.SHORT_DIV(WORD_W), .LONG_DIV(LONG_DIV)) u_div (
      .clk     (clk),
      .rst     (rst),
      .hold    (slip_pulse),
      .count   (div_count),
      .strobes (strobes)
   );

   // Shift register
   logic [WORD_W-1:0] next_word;

   deser_shifter #(.W(WORD_W)) u_shift (
      .clk       (clk),
      .rst       (rst),
      .din       (din),
      .next_word (next_word),
      .tail_bit  (ser_out)
   );

   // Parallel capture
   logic load;
   assign load = wide_mode ? strobes.long_stb : strobes.short_stb;

   always_ff @(posedge clk) begin
      if (rst)       par_out <= '0;
      else if (load) par_out <= next_word;
   end

   assign stb_short = strobes.short_stb;
   assign stb_long  = strobes.long_stb;

endmodule

// File: rtl/bitslip_deser_chk.sv
module bitslip_deser_chk #(
   parameter int WORD_W = 4,
   parameter int CNT_W  = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              wide_mode,
   input logic [WORD_W-1:0] par_out,
   input logic              ser_out,
   input logic              stb_short,
   input logic              stb_long,
   input logic              slip,
   input logic [CNT_W-1:0]  cnt
);

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (par_out == '0) && !ser_out && !stb_short && !stb_long);

   assert_long_in_short_R4: assert property (@(posedge clk) disable iff (rst)
      stb_long |-> stb_short);

   assert_short_gap_R4: assert property (@(posedge clk) disable iff (rst)
      stb_short |=> !stb_short);

   assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !(wide_mode ? stb_long : stb_short) |=> $stable(par_out));

   assert_slip_freeze_R6: assert property (@(posedge clk) disable iff (rst)
      slip |=> (cnt == $past(cnt)));

   assert_one_slip_R7: assert property (@(posedge clk) disable iff (rst)
      slip |=> !slip);

   assert_tail_matches_R8: assert property (@(posedge clk) disable iff (rst)
      (wide_mode ? stb_long : stb_short) |=> (ser_out == par_out[0]));

   assert_slip_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      slip |-> !stb_short && !stb_long);

endmodule

bind bitslip_deser bitslip_deser_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .wide_mode (wide_mode),
   .par_out   (par_out),
   .ser_out   (ser_out),
   .stb_short (stb_short),
   .stb_long  (stb_long),
   .slip      (slip_pulse),
   .cnt       (div_count)
);

// File: tb/bitslip_deser_test.sv
module bitslip_deser_test;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic       rst, ser_a, ser_b, src_sel, wide_mode, slip_req;
   logic [3:0] par_out, casc_par;
   logic       ser_out, stb_short, stb_long;
   logic       casc_sout, casc_s4, casc_s8;

   bitslip_deser uut (
      .clk(clk), .rst(rst), .ser_a(ser_a), .ser_b(ser_b), .src_sel(src_sel),
      .wide_mode(wide_mode), .slip_req(slip_req), .par_out(par_out),
      .ser_out(ser_out), .stb_short(stb_short), .stb_long(stb_long));

   // Downstream instance of an 8-bit chain
   bitslip_deser casc (
      .clk(clk), .rst(rst), .ser_a(ser_out), .ser_b(1'b0), .src_sel(1'b0),
      .wide_mode(wide_mode), .slip_req(1'b0), .par_out(casc_par),
      .ser_out(casc_sout), .stb_short(casc_s4), .stb_long(casc_s8));

   int edges;
   always_ff @(posedge clk) begin
      if (rst) edges <= 0;
      else     edges <= edges + 1;
   end

   bit         hist [0:1023];
   int         checks = 0, fails = 0;
   int         next_load, period, swallow_at;
   logic [3:0] exp_q, exp_c;
   bit         prev_sync, done = 1'b0;

   function automatic bit pat(int n, int seed);
      logic [7:0] v;
      v = 8'(n * 13 + seed * 29 + (n >> 3));
      return ^v;
   endfunction

   function automatic logic [3:0] word_at(int last);
      return {hist[last-1], hist[last-2], hist[last-3], hist[last-4]};
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic drive(int e, bit s_lvl, int seed, bit sel);
      bit a, b;
      a = pat(e, seed);
      b = pat(e, seed + 101);
      ser_a = a;
      ser_b = b;
      hist[e] = sel ? b : a;
      // rising request sampled at e+1, counter frozen at edge e+3
      if (s_lvl && !prev_sync) swallow_at = e + 3;
      slip_req  = s_lvl;
      prev_sync = s_lvl;
   endtask

   task automatic do_reset(bit m, bit sel, int seed);
      rst = 1'b1;
      slip_req = 1'b0;
      prev_sync = 1'b0;
      wide_mode = m;
      src_sel = sel;
      ser_a = 1'b0;
      ser_b = 1'b0;
      repeat (3) @(negedge clk);
      chk(par_out == 4'h0, "R1", "par_out in reset", par_out, 0);
      chk(!ser_out && !stb_short && !stb_long, "R1", "ser_out/strobes in reset",
          {ser_out, stb_short, stb_long}, 0);
      rst = 1'b0;
      period = m ? 8 : 4;
      next_load = period;
      exp_q = 4'h0;
      exp_c = 4'h0;
      swallow_at = -100;
      drive(0, 1'b0, seed, sel);
   endtask

   task automatic step(bit s_lvl, int seed, bit sel, bit mid4, bit casc_chk, string tag);
      int   e;
      bit   exp_stb, exp_s;
      logic prim;
      @(negedge clk);
      e = edges;
      if (e == next_load) begin
         exp_q = word_at(e);
         if (wide_mode) exp_c = {hist[e-5], hist[e-6], hist[e-7], hist[e-8]};
         next_load += period;
      end
      if (e == swallow_at - 1) next_load += 1;   // R6: one-bit delay of the next load
      chk(par_out == exp_q, tag, "par_out", par_out, exp_q);
      if (casc_chk) chk(casc_par == exp_c, "R8", "cascade low word", casc_par, exp_c);
      exp_s = (e >= 4) ? hist[e-4] : 1'b0;
      chk(ser_out == exp_s, "R8", "ser_out", ser_out, exp_s);
      prim = wide_mode ? stb_long : stb_short;
      exp_stb = (e == next_load - 1);
      chk(prim == exp_stb, (e == swallow_at - 1) ? "R9" : "R4", "load strobe", prim, exp_stb);
      if (mid4) begin
         exp_stb = (e == next_load - 1) || (e == next_load - 5);
         chk(stb_short == exp_stb, "R4", "stb_short in wide mode", stb_short, exp_stb);
      end
      drive(e, s_lvl, seed, sel);
   endtask

   initial begin
      // R1 R2 R4 R5 R8: narrow mode, primary source
      do_reset(1'b0, 1'b0, 3);
      for (int i = 0; i < 200; i++) step(1'b0, 3, 1'b0, 1'b0, 1'b0, "R2");

      // R3 R6 R9: loopback source, two-clock slip pulses
      do_reset(1'b0, 1'b1, 7);
      for (int i = 0; i < 220; i++) step((i % 17) >= 5 && (i % 17) < 7, 7, 1'b1, 1'b0, 1'b0, "R3 R6");

      // R7: one long held request gives a single slip
      do_reset(1'b0, 1'b0, 11);
      for (int i = 0; i < 160; i++) step(i >= 30 && i < 70, 11, 1'b0, 1'b0, 1'b0, "R7");

      // R4 R5 R8: wide mode with the cascade
      do_reset(1'b1, 1'b0, 19);
      for (int i = 0; i < 240; i++) step(1'b0, 19, 1'b0, 1'b1, 1'b1, "R5");

      // R6 R9 in wide mode, three-clock pulses, loopback source
      do_reset(1'b1, 1'b1, 23);
      for (int i = 0; i < 240; i++) step((i % 19) >= 4 && (i % 19) < 7, 23, 1'b1, 1'b0, 1'b0, "R6 R5");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule